// File: doc/BRIEF.md
# Multi-Operand In-Memory Compute Array

This block is a small row-addressed storage array that can also compute on its own contents. Each row is one full-width word. Besides an ordinary write port and a registered read port, it takes compute commands. A command carries an opcode, a row-select vector with one bit per row, two explicit source row addresses and a destination row address. The result is written into the destination row. The source rows are left untouched unless one of them is also the destination.

There are three groups of operations. Multi-operand logic reduces every row whose select bit is set, using AND, OR, NAND or NOR. Two-operand logic is XOR or XNOR of two addressed rows. Single-row operations are copy, invert, set, reset and one-bit shifts of one addressed row. Every operand is a whole physical row.

A small state machine sequences each command. In the idle state (ST_IDLE), a command is accepted on the rising edge where it is valid. At that edge the operands are read and reduced, and the result is held in a register. The machine then spends exactly one cycle in the write-back state (ST_WRITE), with busy high, and returns to ST_IDLE at the next edge. In that edge it stores the held result. The two transitions are therefore: ST_IDLE to ST_WRITE when a command is accepted, and ST_WRITE to ST_IDLE unconditionally.

Top module: `imc_array`

## Requirements
- R1: After reset, busy is 0, every row holds zero and mem_rdata is zero.
- R2: A conventional write (mem_we=1) stores mem_wdata into row mem_addr at the clock edge. mem_rdata shows the row at mem_addr one clock edge after the address is presented.
- R3: The opcodes AND=0, OR=1, NAND=2 and NOR=3 reduce all rows whose cmd_sel bit is 1 and store the result, or its inverse for NAND and NOR, into row cmd_dst.
- R4: With cmd_sel all zeros, AND stores all ones, OR stores all zeros, NAND stores all zeros and NOR stores all ones.
- R5: The opcodes XOR=4 and XNOR=5 store row cmd_src_a XOR row cmd_src_b into cmd_dst, inverted for XNOR.
- R6: COPY=6 stores row cmd_src_a, NOT=7 stores its inverse, SET=8 stores all ones and RESET=9 stores all zeros, each into cmd_dst.
- R7: SHL=10 and SHR=11 store row cmd_src_a shifted by one bit toward the MSB or the LSB, and the vacated bit is filled with 0.
- R8: A compute command changes no row other than cmd_dst.
- R9: A command is accepted on an edge where cmd_valid=1 and busy=0. busy is then 1 for exactly one cycle, and the result can be read once busy has fallen. A cmd_valid raised while busy=1 is ignored.
- R10: If a conventional write to the destination row falls in the write-back cycle, the compute result is stored and the conventional write is lost. A conventional write to any other row in that cycle still takes effect.
- R11: The opcodes 12 to 15 write no row, but busy still pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Compute command present |
| cmd_op | input | 4 | Operation code |
| cmd_sel | input | ROWS | Row-select vector for multi-operand operations |
| cmd_src_a | input | clog2(ROWS) | First source row |
| cmd_src_b | input | clog2(ROWS) | Second source row |
| cmd_dst | input | clog2(ROWS) | Destination row |
| busy | output | 1 | High during the write-back cycle |
| mem_we | input | 1 | Conventional write enable |
| mem_addr | input | clog2(ROWS) | Conventional read/write row address |
| mem_wdata | input | WIDTH | Conventional write data |
| mem_rdata | output | WIDTH | Registered read data |

## Verification
The assertions assume that the address inputs are always in range and that the inputs are driven to known values once reset is released. The bench meets both by using 16 rows, so every 4-bit address is legal, and by driving every input from tasks away from the active edge. The stimulus sweeps all sixteen opcodes under several select patterns, including empty and full selects. It uses source and destination rows that move from one command to the next. It also injects a command during the busy cycle, and conventional writes both to the destination row and to other rows in that cycle.

// File: rtl/imc_pkg.sv
package imc_pkg;

    typedef enum logic [3:0] {
        OP_AND   = 4'd0,
        OP_OR    = 4'd1,
        OP_NAND  = 4'd2,
        OP_NOR   = 4'd3,
        OP_XOR   = 4'd4,
        OP_XNOR  = 4'd5,
        OP_COPY  = 4'd6,
        OP_NOT   = 4'd7,
        OP_SET   = 4'd8,
        OP_RESET = 4'd9,
        OP_SHL   = 4'd10,
        OP_SHR   = 4'd11
    } imc_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } imc_state_e;

endpackage

// File: rtl/imc_reduce.sv
module imc_reduce #(
    parameter int ROWS  = 16,
    parameter int WIDTH = 16
) (
    input  logic [ROWS*WIDTH-1:0] rows_flat,
    input  logic [ROWS-1:0]       sel,
    output logic [WIDTH-1:0]      or_v,
    output logic [WIDTH-1:0]      and_v
);

    // Empty select leaves the identities: zero for OR, ones for AND
    always_comb begin
        or_v  = '0;
        and_v = '1;
        for (int k = 0; k < ROWS; k++) begin
            if (sel[k]) begin
                or_v  = or_v  | rows_flat[k*WIDTH +: WIDTH];
                and_v = and_v & rows_flat[k*WIDTH +: WIDTH];
            end
        end
    end

endmodule

// File: rtl/imc_rowalu.sv
module imc_rowalu
    import imc_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] row_a,
    input  logic [WIDTH-1:0] row_b,
    input  logic [WIDTH-1:0] or_v,
    input  logic [WIDTH-1:0] and_v,
    output logic [WIDTH-1:0] result,
    output logic             wr_en
);

    imc_op_e op_e;
    assign op_e = imc_op_e'(op);

    always_comb begin
        wr_en  = 1'b1;
        result = '0;
        unique case (op_e)
            OP_AND:   result = and_v;
            OP_OR:    result = or_v;
            OP_NAND:  result = ~and_v;
            OP_NOR:   result = ~or_v;
            OP_XOR:   result = row_a ^ row_b;
            OP_XNOR:  result = ~(row_a ^ row_b);
            OP_COPY:  result = row_a;
            OP_NOT:   result = ~row_a;
            OP_SET:   result = '1;
            OP_RESET: result = '0;
            OP_SHL:   result = {row_a[WIDTH-2:0], 1'b0};
            OP_SHR:   result = {1'b0, row_a[WIDTH-1:1]};
            default:  wr_en  = 1'b0;
        endcase
    end

endmodule

// File: rtl/imc_ctrl.sv
module imc_ctrl
    import imc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    output logic accept,
    output logic busy
);

    imc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cmd_valid) state_d = ST_WRITE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept = 1'b0;
        busy   = 1'b0;
        unique case (state_q)
            ST_IDLE:  accept = cmd_valid;
            ST_WRITE: busy   = 1'b1;
            default:  busy   = 1'b0;
        endcase
    end

endmodule

// File: rtl/imc_array.sv
module imc_array
    import imc_pkg::*;
#(
    parameter int ROWS  = 16,
    parameter int WIDTH = 16,
    localparam int AW   = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    input  logic [ROWS-1:0]  cmd_sel,
    input  logic [AW-1:0]    cmd_src_a,
    input  logic [AW-1:0]    cmd_src_b,
    input  logic [AW-1:0]    cmd_dst,
    output logic             busy,
    input  logic             mem_we,
    input  logic [AW-1:0]    mem_addr,
    input  logic [WIDTH-1:0] mem_wdata,
    output logic [WIDTH-1:0] mem_rdata
);

    logic [WIDTH-1:0]      mem_q [ROWS];
    logic [ROWS*WIDTH-1:0] rows_flat;
    logic                  accept;
    logic [WIDTH-1:0]      or_v, and_v, alu_res;
    logic                  alu_we;
    logic [WIDTH-1:0]      res_q;
    logic [AW-1:0]         dst_q;
    logic                  res_we_q;

    for (genvar g = 0; g < ROWS; g++) begin : g_flat
        assign rows_flat[g*WIDTH +: WIDTH] = mem_q[g];
    end

    imc_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .accept    (accept),
        .busy      (busy)
    );

    imc_reduce #(.ROWS(ROWS), .WIDTH(WIDTH)) reduce_i (
        .rows_flat (rows_flat),
        .sel       (cmd_sel),
        .or_v      (or_v),
        .and_v     (and_v)
    );

    imc_rowalu #(.WIDTH(WIDTH)) alu_i (
        .op     (cmd_op),
        .row_a  (mem_q[cmd_src_a]),
        .row_b  (mem_q[cmd_src_b]),
        .or_v   (or_v),
        .and_v  (and_v),
        .result (alu_res),
        .wr_en  (alu_we)
    );

    // Read-and-reduce happens on the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q    <= '0;
            dst_q    <= '0;
            res_we_q <= 1'b0;
        end else if (accept) begin
            res_q    <= alu_res;
            dst_q    <= cmd_dst;
            res_we_q <= alu_we;
        end
    end

    // Storage: compute write-back wins over a conventional write to the same row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ROWS; k++) mem_q[k] <= '0;
        end else begin
            for (int k = 0; k < ROWS; k++) begin
                if (busy && res_we_q && (int'(dst_q) == k))
                    mem_q[k] <= res_q;
                else if (mem_we && (int'(mem_addr) == k))
                    mem_q[k] <= mem_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_rdata <= '0;
        else        mem_rdata <= mem_q[mem_addr];
    end

endmodule

// File: rtl/imc_array_chk.sv
module imc_array_chk #(
    parameter int ROWS  = 16,
    parameter int WIDTH = 16,
    localparam int AW   = $clog2(ROWS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_valid,
    input logic                  busy,
    input logic                  mem_we,
    input logic [AW-1:0]         mem_addr,
    input logic [AW-1:0]         dst_q,
    input logic [WIDTH-1:0]      res_q,
    input logic                  res_we_q,
    input logic [ROWS*WIDTH-1:0] rows_flat
);

    logic [WIDTH-1:0] dst_row;
    assign dst_row = rows_flat[int'(dst_q)*WIDTH +: WIDTH];

    // R9: busy lasts exactly one cycle
    p_busy_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R9: an idle valid command raises busy
    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    // R9: no command, no busy
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !busy) |=> !busy);

    // R10: write-back result survives a colliding conventional write
    p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && res_we_q && mem_we && mem_addr == dst_q) |=> (dst_row == $past(res_q)));

    // R8: a row changes only when it is written
    for (genvar g = 0; g < ROWS; g++) begin : g_hold
        p_row_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!(busy && res_we_q && int'(dst_q) == g) && !(mem_we && int'(mem_addr) == g))
            |=> $stable(rows_flat[g*WIDTH +: WIDTH]));
    end

endmodule

bind imc_array imc_array_chk #(.ROWS(ROWS), .WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .dst_q     (dst_q),
    .res_q     (res_q),
    .res_we_q  (res_we_q),
    .rows_flat (rows_flat)
);

// File: tb/imc_array_tb_top.sv
module imc_array_tb_top;

    localparam int ROWS  = 16;
    localparam int WIDTH = 16;
    localparam int AW    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [3:0]       cmd_op = '0;
    logic [ROWS-1:0]  cmd_sel = '0;
    logic [AW-1:0]    cmd_src_a = '0;
    logic [AW-1:0]    cmd_src_b = '0;
    logic [AW-1:0]    cmd_dst = '0;
    logic             busy;
    logic             mem_we = 1'b0;
    logic [AW-1:0]    mem_addr = '0;
    logic [WIDTH-1:0] mem_wdata = '0;
    logic [WIDTH-1:0] mem_rdata;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [WIDTH-1:0] model [ROWS];

    always #2 clk = ~clk;

    imc_array #(.ROWS(ROWS), .WIDTH(WIDTH)) dut_i (.*);

    task automatic check(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_row(input int a, input logic [WIDTH-1:0] d);
        @(negedge clk);
        mem_we = 1'b1; mem_addr = AW'(a); mem_wdata = d;
        @(negedge clk);
        mem_we = 1'b0;
        model[a] = d;
    endtask

    task automatic rd_row(input int a, output logic [WIDTH-1:0] d);
        @(negedge clk);
        mem_addr = AW'(a);
        @(negedge clk);
        d = mem_rdata;
    endtask

    function automatic string req_of(input int op);
        if (op <= 3)  return "R3";
        if (op <= 5)  return "R5";
        if (op <= 9)  return "R6";
        if (op <= 11) return "R7";
        return "R11";
    endfunction

    function automatic logic [WIDTH-1:0] expect_res(input int op, input logic [ROWS-1:0] sel,
                                                    input int a, input int b, output bit we);
        logic [WIDTH-1:0] orr = '0;
        logic [WIDTH-1:0] andr = '1;
        logic [WIDTH-1:0] r = '0;
        for (int k = 0; k < ROWS; k++) if (sel[k]) begin orr |= model[k]; andr &= model[k]; end
        we = 1'b1;
        case (op)
            0: r = andr;
            1: r = orr;
            2: r = ~andr;
            3: r = ~orr;
            4: r = model[a] ^ model[b];
            5: r = ~(model[a] ^ model[b]);
            6: r = model[a];
            7: r = ~model[a];
            8: r = '1;
            9: r = '0;
            10: r = model[a] * 2;
            11: r = model[a] / 2;
            default: we = 1'b0;
        endcase
        return r;
    endfunction

    // mode: 0 plain, 1 inject ignored command, 2 collide on dst, 3 write other row
    task automatic do_cmd(input int op, input logic [ROWS-1:0] sel, input int a, input int b,
                          input int d, input int mode, input logic [WIDTH-1:0] wd);
        bit we;
        logic [WIDTH-1:0] r, got;
        int other;
        r = expect_res(op, sel, a, b, we);
        other = (d + 5) % ROWS;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 4'(op); cmd_sel = sel;
        cmd_src_a = AW'(a); cmd_src_b = AW'(b); cmd_dst = AW'(d);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R9 busy after accept", {15'b0, busy}, 16'd1);
        if (mode == 1) begin
            cmd_valid = 1'b1; cmd_op = 4'd8; cmd_dst = AW'((d + 1) % ROWS);
        end
        if (mode == 2) begin mem_we = 1'b1; mem_addr = AW'(d); mem_wdata = wd; end
        if (mode == 3) begin mem_we = 1'b1; mem_addr = AW'(other); mem_wdata = wd; end
        @(negedge clk);
        cmd_valid = 1'b0; mem_we = 1'b0;
        check("R9 busy falls", {15'b0, busy}, 16'd0);
        if (we) model[d] = r;
        else if (mode == 2) model[d] = wd;
        if (mode == 3) model[other] = wd;
        rd_row(d, got);
        check(req_of(op), got, model[d]);
        if (mode == 1) begin
            rd_row((d + 1) % ROWS, got);
            check("R9 ignored while busy", got, model[(d + 1) % ROWS]);
        end
        if (mode == 2) check("R10 compute wins", got, model[d]);
        if (mode == 3) begin
            rd_row(other, got);
            check("R10 other row write", got, model[other]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [WIDTH-1:0] got;
        logic [ROWS-1:0] sel;
        for (int k = 0; k < ROWS; k++) model[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 busy", {15'b0, busy}, 16'd0);
        check("R1 rdata", mem_rdata, '0);
        for (int k = 0; k < ROWS; k++) begin
            rd_row(k, got);
            check("R1 row zero", got, '0);
        end

        // R4: empty select on a populated array
        for (int k = 0; k < ROWS; k++) wr_row(k, WIDTH'(k * 16'h1111 + 3));
        do_cmd(0, '0, 0, 0, 2, 0, '0);
        check("R4 AND empty", model[2], 16'hFFFF);
        do_cmd(1, '0, 0, 0, 3, 0, '0);
        check("R4 OR empty", model[3], 16'h0000);
        do_cmd(2, '0, 0, 0, 4, 0, '0);
        check("R4 NAND empty", model[4], 16'h0000);
        do_cmd(3, '0, 0, 0, 5, 0, '0);
        check("R4 NOR empty", model[5], 16'hFFFF);

        for (int t = 0; t < 4; t++) begin
            for (int k = 0; k < ROWS; k++) wr_row(k, WIDTH'((k + 1) * 16'h3A7 ^ (t * 16'h5C1D)));
            for (int k = 0; k < ROWS; k++) begin
                rd_row(k, got);
                check("R2 write/read", got, model[k]);
            end
            for (int op = 0; op < 16; op++) begin
                for (int s = 0; s < 4; s++) begin
                    case (s)
                        0: sel = '1;
                        1: sel = ROWS'(16'h1 << ((op + t) % ROWS));
                        2: sel = ROWS'(op * 16'h9E37 + t * 16'h3A5 + 16'h1234);
                        default: sel = ROWS'(16'h8421 << t);
                    endcase
                    do_cmd(op, sel, (op * 5 + t + s) % ROWS, (op * 7 + t + 1 + s) % ROWS,
                           (op + t * 3 + s * 4) % ROWS, (op + s) % 4, WIDTH'(16'hBEEF ^ (op << 4)));
                end
            end
            for (int k = 0; k < ROWS; k++) begin
                rd_row(k, got);
                check("R8 rows match model", got, model[k]);
            end
        end

        // R7: explicit vacated-bit fill
        wr_row(1, 16'hFFFF);
        do_cmd(10, '0, 1, 0, 6, 0, '0);
        check("R7 SHL fill", model[6], 16'hFFFE);
        do_cmd(11, '0, 1, 0, 7, 0, '0);
        check("R7 SHR fill", model[7], 16'h7FFF);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule